// File: doc/BRIEF.md
# Extended Audio Control Register File

This block holds the extended audio control state of a codec, reached through a plain register port. The port has an address, write data, a write strobe and a read strobe. It stores three enables: variable-rate mode, double-rate mode and the serial digital output. It also stores the output slot-pair selector, a second slot-pair field used for double-rate transfers, four converter sample-rate registers and a serial-output configuration word. The stored values are decoded into control signals for the audio datapath.

The block enforces two interlocks between registers. While variable-rate mode is off, the rate registers keep whatever was written to them but read back the fixed 48 kHz code 0xBB80. The converters also run at 48 kHz in that state, or at 96 kHz when double-rate mode is on. While the serial output is enabled, the configuration word is locked except for bit 14. A read returns its data one clock after the read strobe.

Top module: `ext_audio_regs`

## Requirements
- R1: After reset the control enables (variable-rate, double-rate, serial output) are 0. The output slot selector is 2'b11. The double-rate slot field and the configuration word are 0. Every rate register holds 0xBB80, and `rdata` is 0.
- R2: The control register sits at address 0x2A. Bit 0 is the variable-rate enable, bit 1 the double-rate enable, bit 2 the serial-output enable and bits 5:4 the output slot selector. Bit 3 and bits 15:6 always read 0, whatever was written.
- R3: While the variable-rate enable is 0, a read of the rate registers at 0x2C, 0x2E, 0x30 or 0x32 returns 0xBB80, whatever they hold.
- R4: Writes to the rate registers are stored in either mode. Once the variable-rate enable is 1, reads return the stored values.
- R5: Each converter's effective rate, 17 bits per converter, is its stored value when variable-rate is on and 48000 when it is off. The result is doubled when double-rate is on, so double-rate with variable-rate off gives 96000.
- R6: While the serial-output enable is 1, a write to the configuration register at 0x3A leaves bit 15 and bits 13:0 unchanged. While it is 0, all 16 bits are written.
- R7: Bit 14 of the configuration register takes the written value on every write, whether the serial output is enabled or not.
- R8: The double-rate slot field is bits 5:4 of address 0x28 and reads back as stored, with all other bits 0. Its datapath output `dbl_slot` is 2'b00 while the double-rate enable is 1, and equals the stored field otherwise.
- R9: A read of any other address, including odd addresses, returns 0.
- R10: A read presents its data on `rdata` in the cycle after `rd_en`, taken from the state before any write in the same cycle. Otherwise `rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| vra_en | output | 1 | Variable-rate enable |
| dra_en | output | 1 | Double-rate enable |
| sdo_en | output | 1 | Serial digital output enable |
| sdo_slot | output | 2 | Output slot-pair selector |
| dbl_slot | output | 2 | Double-rate slot field, masked while double-rate is on |
| rate_eff | output | 68 | Four 17-bit effective converter rates, converter 0 in the low bits |
| sdo_cfg | output | 16 | Serial-output configuration word |

## Verification
The bench builds the block with its default of four rate registers and a 7-bit address. This covers every rate slot, the odd addresses that fall between them, and the addresses just past the last rate register. A behavioural model in the bench is compared on every clock. The stimulus toggles variable-rate and double-rate in all four combinations while rate values are stored. It also writes the configuration word with the serial output enabled and disabled, using patterns that separate bit 14 from its neighbours.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned EFF_W  = DATA_W + 1;

  localparam logic [ADDR_W-1:0] A_DBL   = 7'h28;
  localparam logic [ADDR_W-1:0] A_CTRL  = 7'h2A;
  localparam logic [ADDR_W-1:0] A_RATE0 = 7'h2C;
  localparam logic [ADDR_W-1:0] A_SDO   = 7'h3A;

  localparam logic [DATA_W-1:0] RATE_48K = 16'hBB80;
  localparam int unsigned       SDO_FREE_BIT = 14;

  // Address of rate register idx
  function automatic logic [ADDR_W-1:0] rate_addr(input int unsigned idx);
    return ADDR_W'(int'(A_RATE0) + 2 * int'(idx));
  endfunction

  // Effective converter rate from stored code and mode bits
  function automatic logic [EFF_W-1:0] eff_rate(input logic [DATA_W-1:0] stored,
                                                input logic vre, input logic dre);
    logic [DATA_W-1:0] base;
    base = vre ? stored : RATE_48K;
    return dre ? {base, 1'b0} : {1'b0, base};
  endfunction
endpackage

// File: rtl/eac_ctrl_reg.sv
module eac_ctrl_reg
  import eac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_dbl,
  input  logic [DATA_W-1:0] wdata,
  output logic              vre,
  output logic              dre,
  output logic              soe,
  output logic [1:0]        slot,
  output logic [1:0]        dbl_raw,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] dbl_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vre  <= 1'b0;
      dre  <= 1'b0;
      soe  <= 1'b0;
      slot <= 2'b11;
    end else if (wr_ctrl) begin
      vre  <= wdata[0];
      dre  <= wdata[1];
      soe  <= wdata[2];
      slot <= wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbl_raw <= 2'b00;
    else if (wr_dbl) dbl_raw <= wdata[5:4];
  end

  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd[0]   = vre;
    ctrl_rd[1]   = dre;
    ctrl_rd[2]   = soe;
    ctrl_rd[5:4] = slot;
    dbl_rd       = '0;
    dbl_rd[5:4]  = dbl_raw;
  end
endmodule

// File: rtl/eac_rate_bank.sv
module eac_rate_bank
  import eac_pkg::*;
#(
  parameter int unsigned NUM_RATES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_RATES-1:0]        wr_sel,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        vre,
  input  logic                        dre,
  output logic [NUM_RATES*DATA_W-1:0] stored,
  output logic [NUM_RATES*EFF_W-1:0]  eff
);
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val <= RATE_48K;
      else if (wr_sel[g]) val <= wdata;
    end
    assign stored[g*DATA_W +: DATA_W] = val;
    assign eff[g*EFF_W +: EFF_W]      = eff_rate(val, vre, dre);
  end
endmodule

// File: rtl/eac_sdo_cfg.sv
module eac_sdo_cfg
  import eac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              soe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg
);
  localparam logic [DATA_W-1:0] FREE_MASK = DATA_W'(1) << SDO_FREE_BIT;

  logic wr_locked;
  logic wr_open;
  assign wr_locked = wr_hit & soe;
  assign wr_open   = wr_hit & ~soe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg <= '0;
    else if (wr_open)   cfg <= wdata;
    else if (wr_locked) cfg <= (cfg & ~FREE_MASK) | (wdata & FREE_MASK);
  end

  // R6
  locked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_locked |=> (cfg[15] == $past(cfg[15])) && (cfg[13:0] == $past(cfg[13:0])));

  // R7
  free_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cfg[SDO_FREE_BIT] == $past(wdata[SDO_FREE_BIT]));
endmodule

// File: rtl/ext_audio_regs.sv
module ext_audio_regs
  import eac_pkg::*;
#(
  parameter int unsigned NUM_RATES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       vra_en,
  output logic                       dra_en,
  output logic                       sdo_en,
  output logic [1:0]                 sdo_slot,
  output logic [1:0]                 dbl_slot,
  output logic [NUM_RATES*EFF_W-1:0] rate_eff,
  output logic [DATA_W-1:0]          sdo_cfg
);
  logic [NUM_RATES-1:0]        rate_hit;
  logic [NUM_RATES*DATA_W-1:0] rate_stored;
  logic [DATA_W-1:0]           ctrl_rd, dbl_rd, rd_mux;
  logic [1:0]                  dbl_raw;
  logic                        hit_ctrl, hit_dbl, hit_sdo, hit_rate, hit_any;

  assign hit_ctrl = (addr == A_CTRL);
  assign hit_dbl  = (addr == A_DBL);
  assign hit_sdo  = (addr == A_SDO);
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_dec
    assign rate_hit[g] = (addr == rate_addr(g));
  end
  assign hit_rate = |rate_hit;
  assign hit_any  = hit_ctrl | hit_dbl | hit_sdo | hit_rate;

  eac_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_en & hit_ctrl),
    .wr_dbl  (wr_en & hit_dbl),
    .wdata   (wdata),
    .vre     (vra_en),
    .dre     (dra_en),
    .soe     (sdo_en),
    .slot    (sdo_slot),
    .dbl_raw (dbl_raw),
    .ctrl_rd (ctrl_rd),
    .dbl_rd  (dbl_rd)
  );

  eac_rate_bank #(.NUM_RATES(NUM_RATES)) u_rates (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (rate_hit & {NUM_RATES{wr_en}}),
    .wdata  (wdata),
    .vre    (vra_en),
    .dre    (dra_en),
    .stored (rate_stored),
    .eff    (rate_eff)
  );

  eac_sdo_cfg u_sdo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_en & hit_sdo),
    .soe    (sdo_en),
    .wdata  (wdata),
    .cfg    (sdo_cfg)
  );

  assign dbl_slot = dra_en ? 2'b00 : dbl_raw;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_rd;
    if (hit_dbl)  rd_mux = dbl_rd;
    if (hit_sdo)  rd_mux = sdo_cfg;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (rate_hit[i]) rd_mux = vra_en ? rate_stored[i*DATA_W +: DATA_W] : RATE_48K;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R3
  rate_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_rate && !vra_en) |=> rdata == RATE_48K);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_any) |=> rdata == '0);

  // R2
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_ctrl) |=> (rdata[3] == 1'b0) && (rdata[15:6] == '0));

  // R8
  dbl_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dra_en |-> dbl_slot == 2'b00);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_ext_audio_regs.sv
module test_ext_audio_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        vra_en, dra_en, sdo_en;
  logic [1:0]  sdo_slot, dbl_slot;
  logic [NR*17-1:0] rate_eff;
  logic [15:0] sdo_cfg;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_audio_regs #(.NUM_RATES(NR)) i_ext_audio_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vra_en(vra_en), .dra_en(dra_en),
    .sdo_en(sdo_en), .sdo_slot(sdo_slot), .dbl_slot(dbl_slot),
    .rate_eff(rate_eff), .sdo_cfg(sdo_cfg)
  );

  // Behavioural reference model
  int    m_vre, m_dre, m_soe, m_slot, m_dbl, m_cfg, m_rdata;
  int    m_rate [NR];
  string m_tag = "R1";

  function automatic int model_read(input int a, output string tag);
    if (a == 'h2A) begin tag = "R2"; return m_slot*16 + m_soe*4 + m_dre*2 + m_vre; end
    if (a == 'h28) begin tag = "R8"; return m_dbl*16; end
    if (a == 'h3A) begin tag = "R6"; return m_cfg; end
    for (int k = 0; k < NR; k++)
      if (a == 'h2C + 2*k) begin
        if (m_vre == 0) begin tag = "R3"; return 48000; end
        tag = "R4"; return m_rate[k];
      end
    tag = "R9";
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vre <= 0; m_dre <= 0; m_soe <= 0; m_slot <= 3; m_dbl <= 0; m_cfg <= 0;
      m_rdata <= 0; m_tag <= "R1";
      for (int k = 0; k < NR; k++) m_rate[k] <= 48000;
    end else begin
      if (rd_en) begin
        string t;
        int v;
        v = model_read(int'(addr), t);
        m_rdata <= v;
        m_tag <= t;
      end
      if (wr_en) begin
        if (addr == 7'h2A) begin
          m_vre <= wdata[0]; m_dre <= wdata[1]; m_soe <= wdata[2]; m_slot <= wdata[5:4];
        end
        if (addr == 7'h28) m_dbl <= wdata[5:4];
        if (addr == 7'h3A) begin
          if (m_soe != 0) m_cfg <= (m_cfg & 'hBFFF) | (int'(wdata) & 'h4000);
          else            m_cfg <= int'(wdata);
        end
        for (int k = 0; k < NR; k++)
          if (int'(addr) == 'h2C + 2*k) m_rate[k] <= int'(wdata);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(rdata), m_rdata, m_tag);
      chk(int'(vra_en), m_vre, "R2 vra_en");
      chk(int'(dra_en), m_dre, "R2 dra_en");
      chk(int'(sdo_en), m_soe, "R2 sdo_en");
      chk(int'(sdo_slot), m_slot, "R2 sdo_slot");
      chk(int'(dbl_slot), (m_dre != 0) ? 0 : m_dbl, "R8 dbl_slot");
      chk(int'(sdo_cfg), m_cfg, "R6/R7 sdo_cfg");
      for (int k = 0; k < NR; k++) begin
        int base;
        base = (m_vre != 0) ? m_rate[k] : 48000;
        chk(int'(rate_eff[k*17 +: 17]), (m_dre != 0) ? base * 2 : base, "R5 rate_eff");
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(int'(rdata), 0, "R1 rdata");
    chk(int'(sdo_slot), 3, "R1 slot");
    chk(int'({vra_en, dra_en, sdo_en}), 0, "R1 enables");
    chk(int'(rate_eff[16:0]), 48000, "R1 rate0");
    // R1/R3 rate reset readback, R2 control layout, R9 unmapped
    rd('h2C); rd('h2A); rd('h28); rd('h3A);
    rd('h00); rd('h2B); rd('h2D); rd('h34); rd('h7F); rd('h29);
    // R2 reserved bits written as ones
    wr('h2A, 'hFFC8); rd('h2A);
    wr('h2A, 'h0020); rd('h2A);
    // R3 store while forced, R4 restore
    for (int k = 0; k < NR; k++) wr('h2C + 2*k, 'h1F40 + 'h1111*k);
    for (int k = 0; k < NR; k++) rd('h2C + 2*k);
    wr('h2A, 'h0001);
    for (int k = 0; k < NR; k++) rd('h2C + 2*k);
    // R5 all four mode combinations
    wr('h2A, 'h0003); rd('h2C);
    wr('h2A, 'h0002); rd('h2E);
    wr('h2A, 'h0000);
    // R8 double-rate slot field masking
    wr('h28, 'hFFFF); rd('h28);
    wr('h2A, 'h0002); rd('h28);
    wr('h28, 'h0010); wr('h2A, 'h0000); rd('h28);
    // R6/R7 configuration lockout
    wr('h3A, 'h2345); rd('h3A);
    wr('h2A, 'h0004);
    wr('h3A, 'hDCBA); rd('h3A);
    wr('h3A, 'h0000); rd('h3A);
    wr('h3A, 'h4000); rd('h3A);
    wr('h2A, 'h0000);
    wr('h3A, 'hFFFF); rd('h3A);
    // R10 read and write in the same cycle
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 7'h3A; wdata = 16'h0101;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk(int'(rdata), 'hFFFF, "R10 old value");
    rd('h3A);
    repeat (3) @(negedge clk);
    chk(int'(rdata), 'h0101, "R10 hold");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule